// File: doc/BRIEF.md
# DRAM Row Transfer Command Sequencer

This block drives the command side of a whole-row DRAM transfer. A host asks for a number of consecutive rows to be read or written. For every row the sequencer opens the row, walks every column of it at the column-to-column spacing, closes the row, and then waits out the precharge time before the next row may be opened. Reads and writes differ only in the gap between the last column command and the precharge.

All device timings are compile-time cycle counts, so the length of a transfer has a closed form. For one row it is tRCD + (n-1)·tCCD + tRTP + tRP cycles for a read, and tRCD + (n-1)·tCCD + tWL + tDQ + tWR + tRP cycles for a write. Refresh is modelled as a fixed stall. The stall is placed at a row boundary, once the refresh interval has run out, and is never placed before the first row or after the last. The sequencer covers commands only. The physical pins, the data path and training are handled elsewhere.

Top module: `dram_row_seq`

## Requirements
- R1: After reset every strobe and done are low. With the sequencer idle, a request with a nonzero row count is taken at a clock edge, and the activate strobe is high in the very next cycle. A request with a row count of zero, or any request that arrives while a transfer is running, is ignored.
- R2: The first column command of a row is issued exactly T_RCD cycles after that row's activate.
- R3: Each row carries exactly N_COLS column commands. They are spaced T_CCD cycles apart, and the column address shown with them runs 0, 1, …, N_COLS-1.
- R4: When write_i was 0 at acceptance, the column strobe is the read strobe and the precharge follows the last column by T_RTP cycles. When write_i was 1, the column strobe is the write strobe and the gap is T_WL + T_DQ + T_WR cycles.
- R5: When no refresh is due, the next row's activate comes exactly T_RP cycles after the precharge. A read row therefore spans T_RCD + (N_COLS-1)·T_CCD + T_RTP + T_RP cycles.
- R6: The row address shown with each activate is 0 for the first row of a transfer and goes up by one for each later row.
- R7: In any cycle at most one of activate, read, write, precharge and done is high.
- R8: At a boundary where the next activate would fall at cycle a, a refresh stall is taken when a minus the reference point is at least REF_INT. The reference point is the cycle of the transfer's first activate, or the first cycle of the most recent refresh stall. The stall lasts T_RFC cycles with no commands, and the activate follows it. No stall is taken before the first row or after the last row.
- R9: The done signal is a single-cycle pulse exactly T_RP cycles after the last row's precharge. No refresh stall delays it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Transfer request, sampled while idle |
| write_i | input | 1 | 1 = write rows, 0 = read rows; taken with the request |
| rows_i | input | ROW_W | Number of rows to transfer; taken with the request |
| act_o | output | 1 | Activate (open row) strobe |
| rd_o | output | 1 | Read column strobe |
| wr_o | output | 1 | Write column strobe |
| pre_o | output | 1 | Precharge (close row) strobe |
| col_o | output | log2(N_COLS) | Column address, valid with rd_o or wr_o |
| row_o | output | ROW_W | Row address within the transfer, valid with act_o |
| done_o | output | 1 | One-cycle pulse when the transfer is complete |

## Verification
The hardest case to reach is the refresh stall. It appears only after several full rows, and only at a boundary where the interval has just run out. It must never show up in front of the done pulse. The bench uses a shortened refresh interval and requests long multi-row transfers, so that stalls fall at several different row indices. It also issues short transfers, which end with the interval still pending. Throughout every transfer the bench keeps toggling the request, count and direction inputs, and checks every cycle for stray strobes. This shows that inputs arriving mid-transfer are ignored.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ACT,
        ST_WAIT,
        ST_COL,
        ST_PRE,
        ST_REF,
        ST_DONE
    } seq_state_e;

endpackage

// File: rtl/dram_seq_ref_timer.sv
module dram_seq_ref_timer #(
    parameter int REF_INT = 1900
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    output logic due_o
);
    localparam int TW = $clog2(REF_INT + 1);

    logic [TW-1:0] cnt_d, cnt_q;

    // due when the cycle after this one is REF_INT or more past the reference
    assign due_o = (cnt_q >= TW'(REF_INT - 1));

    always_comb begin
        cnt_d = cnt_q;
        if (clear_i)
            cnt_d = '0;
        else if (!due_o)
            cnt_d = cnt_q + TW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/dram_seq_addr.sv
module dram_seq_addr #(
    parameter int N_COLS = 64,
    parameter int ROW_W  = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start_i,
    input  logic                      col_step_i,
    input  logic                      row_step_i,
    output logic [$clog2(N_COLS)-1:0] col_o,
    output logic [ROW_W-1:0]          row_o,
    output logic                      col_last_o
);
    localparam int COL_W = $clog2(N_COLS);

    logic [COL_W-1:0] col_d, col_q;
    logic [ROW_W-1:0] row_d, row_q;

    assign col_last_o = (col_q == COL_W'(N_COLS - 1));
    assign col_o      = col_q;
    assign row_o      = row_q;

    always_comb begin
        col_d = col_q;
        row_d = row_q;
        if (start_i) begin
            col_d = '0;
            row_d = '0;
        end else begin
            if (col_step_i) col_d = col_last_o ? '0 : col_q + COL_W'(1);
            if (row_step_i) row_d = row_q + ROW_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            col_q <= '0;
            row_q <= '0;
        end else begin
            col_q <= col_d;
            row_q <= row_d;
        end
    end
endmodule

// File: rtl/dram_row_seq.sv
module dram_row_seq
    import dram_seq_pkg::*;
#(
    parameter int N_COLS  = 64,
    parameter int ROW_W   = 16,
    parameter int T_RCD   = 4,
    parameter int T_CCD   = 2,
    parameter int T_RTP   = 3,
    parameter int T_RP    = 4,
    parameter int T_WL    = 3,
    parameter int T_DQ    = 2,
    parameter int T_WR    = 4,
    parameter int REF_INT = 1900,
    parameter int T_RFC   = 20
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_i,
    input  logic                      write_i,
    input  logic [ROW_W-1:0]          rows_i,
    output logic                      act_o,
    output logic                      rd_o,
    output logic                      wr_o,
    output logic                      pre_o,
    output logic [$clog2(N_COLS)-1:0] col_o,
    output logic [ROW_W-1:0]          row_o,
    output logic                      done_o
);
    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    localparam int RD_TAIL = T_RTP;
    localparam int WR_TAIL = T_WL + T_DQ + T_WR;
    localparam int DLY_MAX = max2(max2(max2(T_RCD, T_CCD), max2(RD_TAIL, WR_TAIL)),
                                  max2(T_RP, T_RFC));
    localparam int CNT_W   = $clog2(DLY_MAX + 1);

    typedef struct packed {
        seq_state_e       state;
        seq_state_e       tgt;
        logic [CNT_W-1:0] cnt;
        logic [ROW_W-1:0] left;
        logic             wr;
    } fsm_t;

    fsm_t q, d;

    logic ref_due, col_last, start, col_step, row_step, ref_enter;

    // Move toward a one-cycle event dly cycles away; a row open that
    // is due for refresh is deferred behind the refresh stall.
    function automatic fsm_t goto(input fsm_t base, input seq_state_e tgt,
                                  input int dly, input logic due);
        fsm_t r;
        r = base;
        if (dly > 1) begin
            r.state = ST_WAIT;
            r.tgt   = tgt;
            r.cnt   = CNT_W'(dly - 1);
        end else if (tgt == ST_ACT && due) begin
            r.state = ST_REF;
            r.cnt   = CNT_W'(T_RFC);
        end else begin
            r.state = tgt;
        end
        return r;
    endfunction

    always_comb begin
        d        = q;
        start    = 1'b0;
        col_step = 1'b0;
        row_step = 1'b0;
        case (q.state)
            ST_IDLE: begin
                if (req_i && rows_i != '0) begin
                    d.state = ST_ACT;
                    d.left  = rows_i;
                    d.wr    = write_i;
                    start   = 1'b1;
                end
            end
            ST_ACT:  d = goto(q, ST_COL, T_RCD, ref_due);
            ST_WAIT: begin
                if (q.cnt == CNT_W'(1)) d = goto(q, q.tgt, 1, ref_due);
                else                    d.cnt = q.cnt - CNT_W'(1);
            end
            ST_COL: begin
                col_step = 1'b1;
                if (col_last) d = goto(q, ST_PRE, q.wr ? WR_TAIL : RD_TAIL, ref_due);
                else          d = goto(q, ST_COL, T_CCD, ref_due);
            end
            ST_PRE: begin
                row_step = 1'b1;
                d.left   = q.left - ROW_W'(1);
                d = goto(d, (q.left == ROW_W'(1)) ? ST_DONE : ST_ACT, T_RP, ref_due);
            end
            ST_REF: begin
                if (q.cnt == CNT_W'(1)) d.state = ST_ACT;
                else                    d.cnt = q.cnt - CNT_W'(1);
            end
            ST_DONE: d.state = ST_IDLE;
            default: d.state = ST_IDLE;
        endcase
        ref_enter = (d.state == ST_REF) && (q.state != ST_REF);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.state <= ST_IDLE;
            q.tgt   <= ST_IDLE;
            q.cnt   <= '0;
            q.left  <= '0;
            q.wr    <= 1'b0;
        end else begin
            q <= d;
        end
    end

    dram_seq_ref_timer #(.REF_INT(REF_INT)) i_ref_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (start | ref_enter),
        .due_o   (ref_due)
    );

    dram_seq_addr #(.N_COLS(N_COLS), .ROW_W(ROW_W)) i_addr (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start),
        .col_step_i (col_step),
        .row_step_i (row_step),
        .col_o      (col_o),
        .row_o      (row_o),
        .col_last_o (col_last)
    );

    assign act_o  = (q.state == ST_ACT);
    assign rd_o   = (q.state == ST_COL) && !q.wr;
    assign wr_o   = (q.state == ST_COL) &&  q.wr;
    assign pre_o  = (q.state == ST_PRE);
    assign done_o = (q.state == ST_DONE);
endmodule

// File: rtl/dram_row_seq_chk.sv
module dram_row_seq_chk #(
    parameter int N_COLS = 64,
    parameter int T_RCD  = 4,
    parameter int T_CCD  = 2,
    parameter int T_RP   = 4
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      act,
    input logic                      rd,
    input logic                      wr,
    input logic                      pre,
    input logic                      done,
    input logic [$clog2(N_COLS)-1:0] col
);
    logic [15:0] since_act, since_col, since_pre;
    logic        first_pend, pre_seen;
    logic        colcmd;

    assign colcmd = rd | wr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_act  <= '0;
            since_col  <= '0;
            since_pre  <= '0;
            first_pend <= 1'b0;
            pre_seen   <= 1'b0;
        end else begin
            since_act  <= act    ? 16'd1 : (since_act == 16'hFFFF ? since_act : since_act + 16'd1);
            since_col  <= colcmd ? 16'd1 : (since_col == 16'hFFFF ? since_col : since_col + 16'd1);
            since_pre  <= pre    ? 16'd1 : (since_pre == 16'hFFFF ? since_pre : since_pre + 16'd1);
            first_pend <= act ? 1'b1 : (colcmd ? 1'b0 : first_pend);
            pre_seen   <= pre ? 1'b1 : (act ? 1'b0 : pre_seen);
        end
    end

    assert_one_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({act, rd, wr, pre, done}));

    assert_first_col_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (colcmd && first_pend) |-> (since_act == 16'(T_RCD)));

    assert_first_col_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (colcmd && first_pend) |-> (col == '0));

    assert_col_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (colcmd && !first_pend) |-> (since_col == 16'(T_CCD)));

    assert_act_after_pre_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (act && pre_seen) |-> (since_pre >= 16'(T_RP)));

    assert_done_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (pre_seen && since_pre == 16'(T_RP)));

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

bind dram_row_seq dram_row_seq_chk #(
    .N_COLS (N_COLS),
    .T_RCD  (T_RCD),
    .T_CCD  (T_CCD),
    .T_RP   (T_RP)
) i_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .act   (act_o),
    .rd    (rd_o),
    .wr    (wr_o),
    .pre   (pre_o),
    .done  (done_o),
    .col   (col_o)
);

// File: tb/test_dram_row_seq.sv
module test_dram_row_seq;
    localparam int N_COLS  = 64;
    localparam int ROW_W   = 16;
    localparam int T_RCD   = 4;
    localparam int T_CCD   = 2;
    localparam int T_RTP   = 3;
    localparam int T_RP    = 4;
    localparam int T_WL    = 3;
    localparam int T_DQ    = 2;
    localparam int T_WR    = 4;
    localparam int REF_INT = 600;
    localparam int T_RFC   = 7;

    // strobe vector {act, rd, wr, pre, done}
    localparam logic [4:0] V_ACT  = 5'b10000;
    localparam logic [4:0] V_RD   = 5'b01000;
    localparam logic [4:0] V_WR   = 5'b00100;
    localparam logic [4:0] V_PRE  = 5'b00010;
    localparam logic [4:0] V_DONE = 5'b00001;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_i = 1'b0;
    logic write_i = 1'b0;
    logic [ROW_W-1:0] rows_i = '0;
    logic act_o, rd_o, wr_o, pre_o, done_o;
    logic [$clog2(N_COLS)-1:0] col_o;
    logic [ROW_W-1:0] row_o;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  noise_en = 1'b0;
    bit  finished = 1'b0;
    int  n_refresh = 0;

    always #5 clk = ~clk;

    dram_row_seq #(
        .N_COLS(N_COLS), .ROW_W(ROW_W), .T_RCD(T_RCD), .T_CCD(T_CCD),
        .T_RTP(T_RTP), .T_RP(T_RP), .T_WL(T_WL), .T_DQ(T_DQ), .T_WR(T_WR),
        .REF_INT(REF_INT), .T_RFC(T_RFC)
    ) i_dram_row_seq (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .write_i(write_i), .rows_i(rows_i),
        .act_o(act_o), .rd_o(rd_o), .wr_o(wr_o), .pre_o(pre_o),
        .col_o(col_o), .row_o(row_o), .done_o(done_o)
    );

    function automatic logic [4:0] strobes();
        return {act_o, rd_o, wr_o, pre_o, done_o};
    endfunction

    function automatic int pre_tail(input bit wr);
        return wr ? (T_WL + T_DQ + T_WR) : T_RTP;
    endfunction

    task automatic check(input bit ok, input string rq, input string what,
                         input longint act_v, input longint exp_v);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act_v, exp_v);
        end
    endtask

    task automatic drive_noise();
        if (noise_en) begin
            req_i   = 1'($urandom % 2);
            write_i = 1'($urandom % 2);
            rows_i  = ROW_W'($urandom % 8);
        end
    endtask

    task automatic quiet_cycle(input string rq);
        @(negedge clk);
        drive_noise();
        check(strobes() == 5'b0, rq, "stray strobe in gap", strobes(), 0);
    endtask

    task automatic expect_evt(input int gap, input logic [4:0] vexp, input string rq);
        for (int i = 1; i < gap; i++) quiet_cycle(rq);
        @(negedge clk);
        drive_noise();
        check(strobes() == vexp, rq, "strobe vector", strobes(), vexp);
    endtask

    // Expected schedule computed from R1..R9, relative to the first activate.
    task automatic run_xfer(input int rows, input bit wr);
        int rel;
        int ref_pt;
        int gap;
        int a;
        rows_i  = ROW_W'(rows);
        write_i = wr;
        req_i   = 1'b1;
        expect_evt(1, V_ACT, "R1");
        noise_en = 1'b1;
        check(row_o == 0, "R6", "row of first activate", row_o, 0);
        rel    = 0;
        ref_pt = 0;
        for (int r = 0; r < rows; r++) begin
            if (r > 0) begin
                gap = T_RP;
                a   = rel + T_RP;
                if (a - ref_pt >= REF_INT) begin
                    gap    = gap + T_RFC;
                    ref_pt = a;
                    n_refresh++;
                    expect_evt(gap, V_ACT, "R8");
                end else begin
                    expect_evt(gap, V_ACT, "R5");
                end
                rel = rel + gap;
                check(row_o == ROW_W'(r), "R6", "row address", row_o, r);
            end
            for (int k = 0; k < N_COLS; k++) begin
                gap = (k == 0) ? T_RCD : T_CCD;
                expect_evt(gap, wr ? V_WR : V_RD, (k == 0) ? "R2" : "R3");
                rel = rel + gap;
                check(col_o == k, "R3", "column address", col_o, k);
            end
            gap = pre_tail(wr);
            expect_evt(gap, V_PRE, "R4");
            rel = rel + gap;
        end
        expect_evt(T_RP, V_DONE, "R9");
        noise_en = 1'b0;
        req_i    = 1'b0;
        @(negedge clk);
        check(done_o == 1'b0, "R9", "done pulse width", done_o, 0);
    endtask

    initial begin
        void'($urandom(32'd1234));
        #23;
        rst_n = 1'b1;
        @(negedge clk);
        check(strobes() == 5'b0, "R1", "strobes after reset", strobes(), 0);
        check(row_o == 0 && col_o == 0, "R1", "addresses after reset", row_o, 0);

        // zero-row request is ignored
        rows_i = '0;
        req_i  = 1'b1;
        for (int i = 0; i < 12; i++) quiet_cycle("R1");
        req_i = 1'b0;

        run_xfer(1, 1'b0);
        run_xfer(1, 1'b1);
        run_xfer(9, 1'b1);
        run_xfer(5, 1'b0);
        for (int t = 0; t < 10; t++) begin
            run_xfer(1 + int'($urandom % 6), 1'($urandom % 2));
            for (int i = 0; i < int'($urandom % 4); i++) @(negedge clk);
        end
        check(n_refresh > 0, "R8", "refresh stalls seen", n_refresh, 1);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #1500000;
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule